// File: doc/BRIEF.md
# Asynchronous Static-Memory Bridge

This block links a synchronous request bus to an asynchronous static memory of 8192 bytes. The memory has one active-low select, one active-high select, an active-low write strobe and an active-low output enable. A client hands over one byte transfer at a time on a valid/ready handshake. The bridge then runs the memory pins through a fixed sequence of phases, so that each asynchronous timing minimum holds. It also decides when its own data drivers may be switched on.

Each phase length is given in nanoseconds as a parameter. A second parameter gives the clock period in picoseconds, and the block rounds every phase up to whole cycles. The write strobe stretch covers the largest of the pulse-width, address-to-end and select-to-end limits. It also covers the output-turn-off plus data-setup limit, and it grows further if the whole write would otherwise be shorter than the write cycle time. After each read, the bridge keeps the memory deselected for a bus turnaround window, so a following write cannot drive against the memory's outputs.

FSM states: `ST_IDLE` (deselected, ready), `ST_RD_ACCESS` (selected, output enable low), `ST_RD_RELEASE` (deselected turnaround), `ST_WR_SETUP` (selected, address settling), `ST_WR_PULSE` (write strobe low), `ST_WR_HOLD` (strobe high, data still driven).

Transitions:
- `ST_IDLE` to `ST_RD_ACCESS` on an accepted read, or to `ST_WR_SETUP` on an accepted write.
- `ST_RD_ACCESS` to `ST_RD_RELEASE` when the access count expires; the byte is captured at that point.
- `ST_RD_RELEASE` to `ST_IDLE` when the turnaround count expires.
- `ST_WR_SETUP` to `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` to `ST_WR_HOLD` when the strobe count expires.
- `ST_WR_HOLD` to `ST_IDLE` after one cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: Whenever the bridge is idle, and out of reset, it holds `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1, `mem_rd_n`=1 and `mem_dq_oe`=0, and it drives `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the transfer, including its turnaround, has finished.
- R3: A read holds the memory selected with `mem_rd_n`=0 and `mem_wr_n`=1 for exactly RD_CYC = ceil(T_RC_NS*1000/CLK_PERIOD_PS) consecutive cycles (14 at the defaults).
- R4: The read byte is sampled from `mem_dq_in` in the last read-access cycle. `rsp_valid` is high for exactly one cycle, starting RD_CYC+1 clock edges after the accepting edge, and `rsp_rdata` carries the byte.
- R5: A write holds `mem_wr_n`=0 for exactly WP_CYC cycles, with the memory selected and `mem_rd_n`=1 throughout. WP_CYC is ceil(max(T_WP_NS, T_AW_NS, T_WHZ_NS+T_DW_NS)*1000/CLK_PERIOD_PS), raised if needed to the write cycle count minus two (13 at the defaults).
- R6: `mem_addr` does not change while `mem_wr_n` is 0.
- R7: `mem_dq_oe` rises only after `mem_wr_n` has been 0 for at least one full cycle. It is still 1 in the first cycle after `mem_wr_n` returns to 1, and it falls only while `mem_wr_n` is 1.
- R8: `mem_dq_oe` is never 1 while `mem_rd_n` is 0. After each read, the memory stays deselected and `req_ready` stays 0 for HZ_CYC = ceil(T_HZ_NS*1000/CLK_PERIOD_PS) cycles (5 at the defaults) before the next transfer can begin.
- R9: A byte written to an address is returned by a later read of that address, across the full 13-bit address range including addresses 0 and 8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 13 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | 1 = bridge drives the data pins |
| mem_dq_in | input | 8 | Byte sampled from the data pins |

## Verification
The assertions assume that `req_valid` is only raised as a single-cycle pulse, and only while `req_ready` is seen high. They also assume that the memory returns the stored byte combinationally whenever it is selected with its output enable low. The stimulus waits for `req_ready` at a falling edge before it pulses `req_valid` for one cycle, and never offers a second request during a transfer. The bench's memory model answers only in the selected-read condition and stores the driven byte on the rising write strobe. It sweeps 256 addresses whose upper eight bits are all distinct, including both ends of the range. The second pass interleaves writes and reads so that every read is followed by a write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctrl_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) rsp_rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_WP_NS       = 45,
    parameter int unsigned T_AW_NS       = 50,
    parameter int unsigned T_DW_NS       = 25,
    parameter int unsigned T_WHZ_NS      = 20,
    parameter int unsigned T_HZ_NS       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC  = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
    localparam int unsigned WC_CYC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_PS);
    localparam int unsigned WP_RAW  = ns_to_cycles(max2(max2(T_WP_NS, T_AW_NS),
                                                        T_WHZ_NS + T_DW_NS),
                                                   CLK_PERIOD_PS);
    // setup and hold cycles add two to the strobe length
    localparam int unsigned WP_CYC  = (WP_RAW + 2 >= WC_CYC) ? WP_RAW : WC_CYC - 2;
    localparam int unsigned HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), HZ_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(HZ_CYC - 1);

    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              pulse_armed_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              cap_en;
    logic              accept;

    assign accept = req_valid && req_ready;

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            addr_q        <= '0;
            wdata_q       <= '0;
            pulse_armed_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            pulse_armed_q <= (state_q == ST_WR_PULSE);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Next state and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d  = ST_RD_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LOAD;
                end
            end
            ST_RD_RELEASE: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin levels per state
    always_comb begin
        req_ready = 1'b0;
        mem_sel_n = 1'b1;
        mem_sel   = 1'b0;
        mem_wr_n  = 1'b1;
        mem_rd_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_rd_n  = 1'b0;
            end
            ST_RD_RELEASE: begin
            end
            ST_WR_SETUP: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_wr_n  = 1'b0;
                mem_dq_oe = pulse_armed_q;
            end
            ST_WR_HOLD: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign cap_en     = (state_q == ST_RD_ACCESS) && tmr_expired;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_dq_oe
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_read_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_wr_n && !mem_sel_n && mem_sel));

    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_write_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_sel_n && mem_sel && mem_rd_n));

    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n && $past(!mem_wr_n)) |-> $stable(mem_addr));

    p_drive_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_wr_n && $past(!mem_wr_n)));

    p_release_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> mem_wr_n);

    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_rd_n);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_wr_n  (mem_wr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    localparam int PERIOD_PS = 4000;
    // Expected phase lengths, rounded up from the nanosecond limits
    localparam int RD_EXP = (55 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int WP_EXP = (50 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int HZ_EXP = (20 * 1000 + PERIOD_PS - 1) / PERIOD_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] model [0:255];

    always #2 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: answers only when selected with output enable low
    assign mem_dq_in = (!mem_sel_n && mem_sel && !mem_rd_n) ? model[mem_addr[12:5]] : 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] sweep_addr(input int i);
        return {i[7:0], i[4:0]};
    endfunction

    function automatic logic [7:0] pat(input int i, input int pass);
        return 8'((i * 37 + 11 + pass * 90) ^ (pass * 8'hA5));
    endfunction

    // Pin monitor
    int we_run = 0, rd_run = 0, since_rd = 1000;
    logic prev_we = 1'b1, prev_rd = 1'b1, prev_oe = 1'b0;
    logic [12:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_wr_n) begin
                we_run++;
                if (!prev_we) chk(mem_addr == prev_addr, "R6 addr", mem_addr, prev_addr);
            end
            if (mem_wr_n && !prev_we) begin
                chk(we_run == WP_EXP, "R5 strobe length", we_run, WP_EXP);
                chk(mem_dq_oe == 1'b1, "R7 hold drive", mem_dq_oe, 1);
                model[mem_addr[12:5]] = mem_dq_out;
                we_run = 0;
            end
            if (!mem_rd_n) begin
                rd_run++;
                chk(!mem_dq_oe, "R8 contention", mem_dq_oe, 0);
            end
            if (mem_rd_n) begin
                if (!prev_rd) begin
                    chk(rd_run == RD_EXP, "R3 read length", rd_run, RD_EXP);
                    rd_run = 0;
                    since_rd = 0;
                end else if (since_rd < 1000) begin
                    since_rd++;
                end
                if (since_rd < HZ_EXP)
                    chk(mem_sel_n && !mem_sel && !req_ready, "R8 turnaround",
                        {mem_sel_n, mem_sel, req_ready}, 3'b100);
            end
            if (mem_dq_oe && !prev_oe) begin
                chk(!mem_wr_n && !prev_we, "R7 drive start", {mem_wr_n, prev_we}, 0);
                chk(since_rd >= HZ_EXP, "R8 gap", since_rd, HZ_EXP);
            end
            if (!mem_dq_oe && prev_oe)
                chk(mem_wr_n, "R7 drive release", mem_wr_n, 1);
            prev_we   = mem_wr_n;
            prev_rd   = mem_rd_n;
            prev_oe   = mem_dq_oe;
            prev_addr = mem_addr;
        end
    end

    task automatic check_idle(input string tag);
        chk(mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe && req_ready,
            tag, {mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe, req_ready}, 6'b101101);
    endtask

    task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
        chk(!req_ready, "R2 busy", req_ready, 0);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [12:0] a, input logic [7:0] exp);
        int lat;
        issue(1'b0, a, 8'h00);
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == RD_EXP + 1, "R4 latency", lat, RD_EXP + 1);
        chk(rsp_rdata == exp, "R9 data", rsp_rdata, exp);
        @(negedge clk);
        chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!rsp_valid && mem_sel_n && mem_wr_n && mem_rd_n, "R1 in reset",
            {rsp_valid, mem_sel_n, mem_wr_n, mem_rd_n}, 4'b0111);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        // Pass 1: fill, then read back
        for (int i = 0; i < 256; i++) do_write(sweep_addr(i), pat(i, 0));
        for (int i = 0; i < 256; i++) do_read(sweep_addr(i), pat(i, 0));
        // Pass 2: each write followed by a read of a mirrored address
        for (int i = 0; i < 256; i++) begin
            do_write(sweep_addr(i), pat(i, 1));
            do_read(sweep_addr(255 - i), (255 - i <= i) ? pat(255 - i, 1) : pat(255 - i, 0));
        end
        repeat (HZ_EXP + 2) @(negedge clk);
        check_idle("R1 final idle");
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule